// File: doc/BRIEF.md
# Dual Parallel I/O Port with Direction Control

This block provides two general-purpose parallel ports, A and B, each `W` bits wide (8 by default), behind a small register interface that a CPU-style bus can write and read. Each port has a data register and a direction register. A direction bit of 1 makes the matching pin an output.

Pins 1 and up are open-drain. Such a pin is pulled low only when it is an output holding a 0, and is released in every other case. Pin 0 of each port has a push-pull driver that follows its data bit whenever it is an output. A driven-high pad can sag under load, so a read of pin 0 returns the stored data bit while the pin is an output, and returns the pad level while it is an input.

The top pin of port B also serves as an active-low interrupt line. While the interrupt request input is high, that pin is pulled low whatever its data and direction bits hold. A build option removes the drivers of port-B pins 5 and 6, so that those pins can only be inputs. Pad inputs are not registered: a data-register read reflects the live pad level in the same cycle. The pads themselves are left to the surrounding logic. The block gives, per pin, a drive enable and a drive value.

Top module: `pio_pair`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all four registers clear to 0. After that edge every `pa_oe`/`pb_oe` bit is 0 and every register reads back as 0.
- R2: On a rising edge with `wr_en` high, `wr_data` is stored in the register that `reg_sel` selects: 0 = port A data, 1 = port A direction, 2 = port B data, 3 = port B direction. Reading selector 1 or 3 returns the stored direction bits.
- R3: For bits 1 to W-1, the drive enable is 1 exactly when the direction bit is 1 and the data bit is 0. The drive value of those bits is always 0.
- R4: For bit 0 of each port, the drive enable equals the direction bit and the drive value equals the data bit.
- R5: A read of a data register (selector 0 or 2) returns, for bit 0, the data bit when the direction bit is 1 and the pad input when it is 0.
- R6: A read of a data register returns, for bits 1 to W-1, the pad input bits combinationally in the same cycle, with no clock edge needed.
- R7: While `irq_req` is high, `pb_oe[W-1]` is 1 and `pb_out[W-1]` is 0, whatever port-B data and direction hold.
- R8: With `ISOLATE_B56` = 1, `pb_oe[5]` and `pb_oe[6]` are always 0, and those pad inputs still read back through selector 2.
- R9: A rising edge with `wr_en` low changes no register, whatever `reg_sel` and `wr_data` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 2 | Register selector for reads and writes |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_data | input | W | Write data |
| rd_data | output | W | Combinational read data for `reg_sel` |
| irq_req | input | 1 | Interrupt request that forces port-B top pin low |
| pa_pad_in | input | W | Port A pad levels |
| pb_pad_in | input | W | Port B pad levels |
| pa_oe | output | W | Port A per-pin drive enable |
| pa_out | output | W | Port A per-pin drive value |
| pb_oe | output | W | Port B per-pin drive enable |
| pb_out | output | W | Port B per-pin drive value |

## Verification
The hardest case to reach from the ports is a pin-0 read that must return the data bit while the pad says otherwise. With an ideal pad model the two values always agree, so that case never shows. The bench therefore models a sagging push-pull pad: a driven-high pin 0 reads low whenever the external level is low. It then sweeps every direction value against several data patterns and pad levels, with the interrupt request toggling. A second instance built with the isolation option takes the same stimulus, so that pins 5 and 6 can be seen to stay undriven.

// File: rtl/pio_pkg.sv
// Shared definitions for the dual parallel port.
// Assumes a 2-bit register selector; the encoding below is the bus-visible map.
package pio_pkg;
    typedef enum logic [1:0] {
        SEL_A_DATA = 2'd0,
        SEL_A_DIR  = 2'd1,
        SEL_B_DATA = 2'd2,
        SEL_B_DIR  = 2'd3
    } pio_sel_e;
endpackage

// File: rtl/pio_regs.sv
// Register bank: data and direction registers for both ports.
// Assumes a write strobe qualified by the selector and a synchronous active-low reset.
module pio_regs
    import pio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   reg_sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] a_dat,
    output logic [W-1:0] a_dir,
    output logic [W-1:0] b_dat,
    output logic [W-1:0] b_dir
);
    localparam int NREG = 4;

    logic [W-1:0] bank [NREG];

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        // Capture write data into register r when it is selected.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank[r] <= '0;
            end else if (wr_en && (reg_sel == 2'(r))) begin
                bank[r] <= wr_data;
            end
        end
    end

    assign a_dat = bank[SEL_A_DATA];
    assign a_dir = bank[SEL_A_DIR];
    assign b_dat = bank[SEL_B_DATA];
    assign b_dir = bank[SEL_B_DIR];
endmodule

// File: rtl/pio_port.sv
// One port: per-pin drive enables, drive values and readback.
// Bit 0 is push-pull; the other bits are open-drain. The top bit can be
// forced low by force_low when FORCE_EN is set. Bits set in NODRIVE_MASK
// never drive. Assumes W >= 2.
module pio_port #(
    parameter int         W            = 8,
    parameter bit         FORCE_EN     = 1'b0,
    parameter logic [W-1:0] NODRIVE_MASK = '0
) (
    input  logic [W-1:0] dat,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] pad_in,
    input  logic         force_low,
    output logic [W-1:0] oe,
    output logic [W-1:0] drv,
    output logic [W-1:0] rdbk
);
    logic frc;

    // Gate the force input by the build option.
    always_comb frc = FORCE_EN & force_low;

    for (genvar i = 0; i < W; i++) begin : g_pin
        if (i == 0) begin : g_pp
            // Push-pull pin: follows data, reads data back while driving.
            always_comb begin
                oe[i]   = dir[i] & ~NODRIVE_MASK[i];
                drv[i]  = dat[i];
                rdbk[i] = dir[i] ? dat[i] : pad_in[i];
            end
        end else if (i == W - 1) begin : g_top
            // Open-drain top pin with optional interrupt force-low.
            always_comb begin
                oe[i]   = ((dir[i] & ~dat[i]) & ~NODRIVE_MASK[i]) | frc;
                drv[i]  = 1'b0;
                rdbk[i] = pad_in[i];
            end
        end else begin : g_od
            // Open-drain pin: pulls low only for an output holding 0.
            always_comb begin
                oe[i]   = (dir[i] & ~dat[i]) & ~NODRIVE_MASK[i];
                drv[i]  = 1'b0;
                rdbk[i] = pad_in[i];
            end
        end
    end
endmodule

// File: rtl/pio_pair.sv
// Top: two parallel ports behind a 4-register bus map.
// Reads are combinational from reg_sel; writes land on the rising edge.
// ISOLATE_B56 removes the drivers of port-B pins 5 and 6 (needs W >= 7).
module pio_pair
    import pio_pkg::*;
#(
    parameter int W           = 8,
    parameter bit ISOLATE_B56 = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   reg_sel,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] rd_data,
    input  logic         irq_req,
    input  logic [W-1:0] pa_pad_in,
    input  logic [W-1:0] pb_pad_in,
    output logic [W-1:0] pa_oe,
    output logic [W-1:0] pa_out,
    output logic [W-1:0] pb_oe,
    output logic [W-1:0] pb_out
);
    localparam logic [W-1:0] B_MASK = ISOLATE_B56 ? (W'(1) << 5) | (W'(1) << 6) : '0;

    logic [W-1:0] a_dat, a_dir, b_dat, b_dir;
    logic [W-1:0] a_rd, b_rd;

    pio_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
        .wr_data(wr_data), .a_dat(a_dat), .a_dir(a_dir),
        .b_dat(b_dat), .b_dir(b_dir)
    );

    pio_port #(.W(W), .FORCE_EN(1'b0), .NODRIVE_MASK('0)) u_pa (
        .dat(a_dat), .dir(a_dir), .pad_in(pa_pad_in), .force_low(1'b0),
        .oe(pa_oe), .drv(pa_out), .rdbk(a_rd)
    );

    pio_port #(.W(W), .FORCE_EN(1'b1), .NODRIVE_MASK(B_MASK)) u_pb (
        .dat(b_dat), .dir(b_dir), .pad_in(pb_pad_in), .force_low(irq_req),
        .oe(pb_oe), .drv(pb_out), .rdbk(b_rd)
    );

    // Select read data for the addressed register.
    always_comb begin
        case (pio_sel_e'(reg_sel))
            SEL_A_DATA: rd_data = a_rd;
            SEL_A_DIR:  rd_data = a_dir;
            SEL_B_DATA: rd_data = b_rd;
            default:    rd_data = b_dir;
        endcase
    end
endmodule

// File: rtl/pio_pair_chk.sv
// Assertion checker for pio_pair, attached by bind below.
// Assumes it sees the top's register outputs through the bind connections.
module pio_pair_chk #(
    parameter int W           = 8,
    parameter bit ISOLATE_B56 = 1'b0
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic         irq_req,
    input logic [W-1:0] pa_oe,
    input logic [W-1:0] pa_out,
    input logic [W-1:0] pb_oe,
    input logic [W-1:0] pb_out,
    input logic [W-1:0] a_dat,
    input logic [W-1:0] a_dir,
    input logic [W-1:0] b_dat,
    input logic [W-1:0] b_dir
);
    // R1: a reset edge leaves every register and drive enable cleared.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (a_dat == '0 && a_dir == '0 && b_dat == '0 && b_dir == '0
                    && pa_oe == '0 && (pb_oe == '0 || irq_req)));

    // R3: open-drain pins never drive high.
    a_r3_od_low_only: assert property (@(posedge clk) disable iff (!rst_n)
        (pa_out[W-1:1] == '0) && (pb_out[W-1:1] == '0));

    // R4: push-pull pin 0 enable follows direction.
    a_r4_pp_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (pa_oe[0] == a_dir[0]) && (pa_out[0] == a_dat[0]));

    // R7: interrupt request pulls the top port-B pin low.
    a_r7_irq_force: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (pb_oe[W-1] && !pb_out[W-1]));

    // R9: no write strobe, no register change.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(a_dat) && $stable(a_dir) && $stable(b_dat) && $stable(b_dir)));

    if (ISOLATE_B56) begin : g_iso
        // R8: isolated pins never drive.
        a_r8_isolated: assert property (@(posedge clk) disable iff (!rst_n)
            pb_oe[6:5] == 2'b00);
    end
endmodule

bind pio_pair pio_pair_chk #(.W(W), .ISOLATE_B56(ISOLATE_B56)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .irq_req(irq_req),
    .pa_oe(pa_oe), .pa_out(pa_out), .pb_oe(pb_oe), .pb_out(pb_out),
    .a_dat(a_dat), .a_dir(a_dir), .b_dat(b_dat), .b_dir(b_dir)
);

// File: tb/sim_pio_pair.sv
// Self-checking bench: sweeps all direction values against data patterns,
// pad levels and interrupt states, on a default and an isolated build.
module sim_pio_pair;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       irq = 1'b0;
    logic [1:0] sel = 2'd0;
    logic [7:0] wd = 8'h00;
    logic [7:0] ext_a = 8'h00, ext_b = 8'h00;

    logic [7:0] rd0, pa_oe0, pa_out0, pb_oe0, pb_out0, pa_pad0, pb_pad0;
    logic [7:0] rd1, pa_oe1, pa_out1, pb_oe1, pb_out1, pb_pad1;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Pad model: bit 0 sags when driven high against a low external level.
    function automatic logic [7:0] pad_of(input logic [7:0] oe, input logic [7:0] o, input logic [7:0] e);
        logic [7:0] p;
        p[0] = oe[0] ? (o[0] & e[0]) : e[0];
        for (int i = 1; i < 8; i++) p[i] = (oe[i] & ~o[i]) ? 1'b0 : e[i];
        return p;
    endfunction

    assign pa_pad0 = pad_of(pa_oe0, pa_out0, ext_a);
    assign pb_pad0 = pad_of(pb_oe0, pb_out0, ext_b);
    assign pb_pad1 = pad_of(pb_oe1, pb_out1, ext_b);

    pio_pair #(.W(8), .ISOLATE_B56(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_sel(sel), .wr_en(wr_en), .wr_data(wd),
        .rd_data(rd0), .irq_req(irq), .pa_pad_in(pa_pad0), .pb_pad_in(pb_pad0),
        .pa_oe(pa_oe0), .pa_out(pa_out0), .pb_oe(pb_oe0), .pb_out(pb_out0)
    );

    pio_pair #(.W(8), .ISOLATE_B56(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .reg_sel(sel), .wr_en(wr_en), .wr_data(wd),
        .rd_data(rd1), .irq_req(irq), .pa_pad_in(ext_a), .pb_pad_in(pb_pad1),
        .pa_oe(pa_oe1), .pa_out(pa_out1), .pb_oe(pb_oe1), .pb_out(pb_out1)
    );

    // Expected drive enable from the requirements.
    function automatic logic [7:0] exp_oe(input logic [7:0] d, input logic [7:0] r,
                                          input logic q, input logic iso);
        logic [7:0] o;
        o = (r & ~d & 8'hFE) | (r & 8'h01);
        if (iso) o = o & 8'h9F;
        if (q) o = o | 8'h80;
        return o;
    endfunction

    function automatic logic [7:0] exp_rd(input logic [7:0] d, input logic [7:0] r,
                                          input logic [7:0] oe, input logic [7:0] e);
        logic [7:0] p;
        p = pad_of(oe, {7'b0, d[0]}, e);
        p[0] = r[0] ? d[0] : e[0];
        return p;
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] v);
        @(negedge clk);
        sel = s; wd = v; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] pats [4];
        pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h3C;

        // R1: reset state
        repeat (3) @(negedge clk);
        ext_a = 8'hFF; ext_b = 8'hFF;
        for (int s = 0; s < 4; s++) begin
            sel = 2'(s); #1;
            if (s == 1 || s == 3) chk("R1 reset dir", rd0, 8'h00);
            else chk("R1 reset data reads pads", rd0, 8'hFF);
        end
        chk("R1 reset pa_oe", pa_oe0, 8'h00);
        chk("R1 reset pb_oe", pb_oe0, 8'h00);
        @(negedge clk); rst_n = 1'b1;

        // Main sweep: R2 R3 R4 R5 R6 R7 R8
        for (int d = 0; d < 256; d++) begin
            for (int k = 0; k < 4; k++) begin
                logic [7:0] da, db, rr;
                rr = 8'(d);
                da = pats[k];
                db = ~pats[k] ^ 8'(d);
                irq = rr[1] ^ k[0];
                ext_a = rr ^ 8'h69;
                ext_b = ~rr ^ 8'(k);
                wr(2'd1, rr);
                wr(2'd0, da);
                wr(2'd3, rr);
                wr(2'd2, db);
                sel = 2'd1; #1; chk("R2 A dir readback", rd0, rr);
                sel = 2'd3; #1; chk("R2 B dir readback", rd0, rr);
                chk("R3 R4 pa_oe", pa_oe0, exp_oe(da, rr, 1'b0, 1'b0));
                chk("R3 R4 pa_out", pa_out0, {7'b0, da[0]});
                chk("R3 R4 R7 pb_oe", pb_oe0, exp_oe(db, rr, irq, 1'b0));
                chk("R3 R4 pb_out", pb_out0, {7'b0, db[0]});
                chk("R8 isolated pb_oe", pb_oe1, exp_oe(db, rr, irq, 1'b1));
                sel = 2'd0; #1;
                chk("R5 R6 A data read", rd0, exp_rd(da, rr, exp_oe(da, rr, 1'b0, 1'b0), ext_a));
                sel = 2'd2; #1;
                chk("R5 R6 R7 B data read", rd0, exp_rd(db, rr, exp_oe(db, rr, irq, 1'b0), ext_b));
                chk("R8 isolated pins read pads", rd1 & 8'h60, ext_b & 8'h60);
            end
        end
        irq = 1'b0;

        // R6: pad change seen with no clock edge
        wr(2'd1, 8'h00);
        @(negedge clk);
        sel = 2'd0; ext_a = 8'h12; #1;
        chk("R6 live read 1", rd0, 8'h12);
        ext_a = 8'hED; #1;
        chk("R6 live read 2", rd0, 8'hED);

        // R9: no write without strobe
        wr(2'd2, 8'h5A);
        @(negedge clk);
        for (int s = 0; s < 4; s++) begin
            sel = 2'(s); wd = 8'hC3; wr_en = 1'b0;
            @(negedge clk);
        end
        sel = 2'd3; #1; chk("R9 B dir unchanged", rd0, 8'hFF);
        sel = 2'd1; #1; chk("R9 A dir unchanged", rd0, 8'h00);
        chk("R9 pb_oe unchanged", pb_oe0, 8'hA5);

        // R1: reset after use
        wr(2'd1, 8'hFF);
        wr(2'd0, 8'h00);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        sel = 2'd1; #1; chk("R1 A dir cleared", rd0, 8'h00);
        sel = 2'd3; #1; chk("R1 B dir cleared", rd0, 8'h00);
        chk("R1 pa_oe cleared", pa_oe0, 8'h00);
        chk("R1 pb_oe cleared", pb_oe0, 8'h00);

        finish_run();
    end
endmodule